// File: doc/BRIEF.md
# Capture/Compare Timer Unit

A free-running 16-bit timer used both to timestamp events and to generate timed pulses. It can count one of several things: a divided internal tick (divide by 1, 2, 4 or 8) or rising edges of an external event input. It can also be stopped. A dedicated external input clears the count on its rising edge. When the count passes 0xFFFF it wraps to 0x0000, raises a sticky overflow flag and keeps counting.

Four capture channels copy the current count into their own register when their input shows the selected edge. Each channel can be set to rising, falling, both, or disabled. Each capture raises a sticky flag. Three compare registers are checked against the count every time the count advances. A match drives six outputs high or low through per-compare set and reset masks, and inverts two further outputs through per-compare toggle masks. All eight outputs update together on a single clock edge.

Software reaches every setting through a simple word-wide register port. Writes are synchronous and reads are combinational.

Top module: `cc_timer_unit`

## Requirements
- R1: After reset the timer reads 0, all eight outputs are 0, the status register reads 0 and the clock source is off, so the timer holds.
- R2: Register 0 bits [2:0] select the clock source: 0 off, 1/2/4/8 for values 1/2/3/4 (one increment every that many clocks), 5 external event. In off, the timer value does not change.
- R3: In event mode the timer increments once for each rising edge of `ext_evt`, and not on falling edges.
- R4: A rising edge on `ext_clr` clears the timer three clocks after the input rises. Holding the input high does not clear it again, and counting resumes from 0.
- R5: An increment from 0xFFFF gives 0x0000, sets status bit 4 (overflow), and counting continues.
- R6: Register 0 bits [2i+9:2i+8] set the edge for capture channel i (00 disabled, 01 rising, 10 falling, 11 both). A selected edge copies the timer into capture register i (address 3+i) and sets status bit i. A disabled channel does neither.
- R7: Status flags (address 2) are cleared by writing 1 to their bit. Writing 0 leaves them set.
- R8: Compare k (address 7+k) matches when the count advances to its value. On a match, the outputs selected in mask register 10+k bits [5:0] go to 1 and those selected in bits [13:8] go to 0. Set wins over reset for the same output, including when the two come from different compares.
- R9: On a match, the toggle outputs selected by register 13 bits [2k+1:2k] invert. If several simultaneous matches select the same output, it inverts once.
- R10: All eight outputs change on the clock edge one cycle after the count reaches the compare value. Outputs not selected keep their level.
- R11: Writing address 1 loads the timer. A load or a clear never produces a compare match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ext_evt | input | 1 | External event count input (asynchronous) |
| ext_clr | input | 1 | External timer clear, rising edge (asynchronous) |
| cap_in | input | 4 | Capture trigger inputs (asynchronous) |
| sr_out | output | 6 | Set/reset match outputs |
| tg_out | output | 2 | Toggle match outputs |

## Verification
The hardest case to reach from the ports is two or three compares matching the same count with conflicting masks. One example is one compare setting a bit while another resets it. Another is two compares toggling the same output. The stimulus loads the timer just below a chosen window and places the compare values inside it. Random trials draw those values from a window of only a few dozen counts, so collisions happen often, and a directed trial forces them. Overflow is reached by loading the timer near 0xFFFF instead of counting through the whole range.

// File: rtl/cc_timer_unit.sv
module cc_timer_unit #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          ext_evt,
  input  logic          ext_clr,
  input  logic [3:0]    cap_in,
  output logic [5:0]    sr_out,
  output logic [1:0]    tg_out
);
  localparam int NCAP = 4;
  localparam int NCMP = 3;
  localparam int NSR  = 6;
  localparam int NTG  = 2;
  localparam int NS   = NCAP + 2;
  localparam int A_CTRL = 0, A_TMR = 1, A_STAT = 2, A_CAP = 3, A_CMP = 7, A_MSK = 10, A_TGL = 13;

  logic [2:0]        sel;
  logic [2*NCAP-1:0] esel;
  logic [W-1:0]      cnt;
  logic [2:0]        div;
  logic              adv, ovf, tick;
  logic [NCAP-1:0]   cflag, cap_ev;
  logic [W-1:0]      cap [NCAP];
  logic [W-1:0]      cmp [NCMP];
  logic [NSR-1:0]    setm [NCMP];
  logic [NSR-1:0]    rstm [NCMP];
  logic [NTG-1:0]    tgm [NCMP];
  logic [NS-1:0]     s1, s2, s3;
  logic [NCMP-1:0]   hit;
  logic [NSR-1:0]    set_v, rst_v;
  logic [NTG-1:0]    tog_v;

  wire [NS-1:0] rise = s2 & ~s3;
  wire [NS-1:0] fall = ~s2 & s3;
  wire clr_rise = rise[1];
  wire twr = reg_we && reg_addr == AW'(A_TMR);
  wire swr = reg_we && reg_addr == AW'(A_STAT);

  always_comb begin
    case (sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = div[0];
      3'd3:    tick = &div[1:0];
      3'd4:    tick = &div;
      3'd5:    tick = rise[0];
      default: tick = 1'b0;
    endcase
  end

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    assign cap_ev[i] = (esel[2*i] & rise[2+i]) | (esel[2*i+1] & fall[2+i]);
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_hit
    assign hit[k] = adv && cnt == cmp[k];
  end

  always_comb begin
    set_v = '0;
    rst_v = '0;
    tog_v = '0;
    for (int k = 0; k < NCMP; k++) begin
      if (hit[k]) begin
        set_v |= setm[k];
        rst_v |= rstm[k];
        tog_v |= tgm[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      sel <= '0; esel <= '0; cnt <= '0; div <= '0;
      adv <= 1'b0; ovf <= 1'b0; cflag <= '0;
      sr_out <= '0; tg_out <= '0;
      for (int i = 0; i < NCAP; i++) cap[i] <= '0;
      for (int k = 0; k < NCMP; k++) begin
        cmp[k] <= '0; setm[k] <= '0; rstm[k] <= '0; tgm[k] <= '0;
      end
    end else begin
      s1 <= {cap_in, ext_clr, ext_evt};
      s2 <= s1;
      s3 <= s2;
      div <= div + 3'd1;
      adv <= tick && !clr_rise && !twr;
      if (clr_rise)  cnt <= '0;
      else if (twr)  cnt <= reg_wdata;
      else if (tick) cnt <= cnt + 1'b1;
      if (tick && &cnt && !clr_rise && !twr) ovf <= 1'b1;
      else if (swr && reg_wdata[NCAP])       ovf <= 1'b0;
      cflag <= (cflag & ~(swr ? reg_wdata[NCAP-1:0] : '0)) | cap_ev;
      for (int i = 0; i < NCAP; i++)
        if (cap_ev[i]) cap[i] <= cnt;
      if (reg_we && reg_addr == AW'(A_CTRL)) begin
        sel  <= reg_wdata[2:0];
        esel <= reg_wdata[8 +: 2*NCAP];
      end
      for (int k = 0; k < NCMP; k++) begin
        if (reg_we && reg_addr == AW'(A_CMP + k)) cmp[k] <= reg_wdata;
        if (reg_we && reg_addr == AW'(A_MSK + k)) begin
          setm[k] <= reg_wdata[NSR-1:0];
          rstm[k] <= reg_wdata[8 +: NSR];
        end
        if (reg_we && reg_addr == AW'(A_TGL)) tgm[k] <= reg_wdata[NTG*k +: NTG];
      end
      sr_out <= (sr_out & ~rst_v) | set_v;
      tg_out <= tg_out ^ tog_v;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(A_CTRL)) reg_rdata = W'({esel, 5'b0, sel});
    if (reg_addr == AW'(A_TMR))  reg_rdata = cnt;
    if (reg_addr == AW'(A_STAT)) reg_rdata = W'({ovf, cflag});
    if (reg_addr == AW'(A_TGL))  reg_rdata = W'({tgm[2], tgm[1], tgm[0]});
    for (int i = 0; i < NCAP; i++)
      if (reg_addr == AW'(A_CAP + i)) reg_rdata = cap[i];
    for (int k = 0; k < NCMP; k++) begin
      if (reg_addr == AW'(A_CMP + k)) reg_rdata = cmp[k];
      if (reg_addr == AW'(A_MSK + k)) reg_rdata = W'({2'b0, rstm[k], 2'b0, setm[k]});
    end
  end
endmodule

// File: rtl/cc_timer_unit_chk.sv
module cc_timer_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt,
  input logic         tick,
  input logic         clr_rise,
  input logic         twr,
  input logic         adv,
  input logic [2:0]   sel,
  input logic         ovf,
  input logic [3:0]   cap_ev,
  input logic [3:0]   cflag,
  input logic [5:0]   sr_out,
  input logic [1:0]   tg_out
);
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (cnt == '0 && sr_out == '0 && tg_out == '0 && !ovf && cflag == '0));

  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0 && !clr_rise && !twr) |=> cnt == $past(cnt));

  assert_clear_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rise |=> cnt == '0);

  assert_wrap_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && &cnt && !clr_rise && !twr) |=> (cnt == '0 && ovf));

  assert_capture_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev != 4'd0) |=> ((cflag & $past(cap_ev)) == $past(cap_ev)));

  assert_outputs_only_on_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(sr_out) && $stable(tg_out)));
endmodule

bind cc_timer_unit cc_timer_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .tick(tick), .clr_rise(clr_rise),
  .twr(twr), .adv(adv), .sel(sel), .ovf(ovf), .cap_ev(cap_ev), .cflag(cflag),
  .sr_out(sr_out), .tg_out(tg_out)
);

// File: tb/test_cc_timer_unit.sv
module test_cc_timer_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic ext_evt = 1'b0, ext_clr = 1'b0;
  logic [3:0] cap_in = '0;
  logic [5:0] sr_out;
  logic [1:0] tg_out;

  always #10 clk = ~clk;

  cc_timer_unit i_cc_timer_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_evt(ext_evt),
    .ext_clr(ext_clr), .cap_in(cap_in), .sr_out(sr_out), .tg_out(tg_out)
  );

  int checks = 0, errors = 0;
  logic [5:0] e_sr = '0;
  logic [1:0] e_tg = '0;
  logic [15:0] d;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] v);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  function automatic void model(input logic [15:0] st, input logic [15:0] f,
                                input logic [15:0] c0, c1, c2,
                                input logic [13:0] m0, m1, m2, input logic [5:0] tgl);
    logic [15:0] c [3];
    logic [13:0] m [3];
    c = '{c0, c1, c2};
    m = '{m0, m1, m2};
    for (int v = int'(st) + 1; v <= int'(f); v++) begin
      logic [5:0] s, r;
      logic [1:0] t;
      s = '0; r = '0; t = '0;
      for (int k = 0; k < 3; k++)
        if (c[k] == v[15:0]) begin
          s |= m[k][5:0];
          r |= m[k][13:8];
          t |= tgl[2*k +: 2];
        end
      e_sr = (e_sr & ~r) | s;
      e_tg = e_tg ^ t;
    end
  endfunction

  task automatic trial(input logic [15:0] st, input logic [15:0] c0, c1, c2,
                       input logic [13:0] m0, m1, m2, input logic [5:0] tgl, input int n);
    logic [15:0] f;
    wr(0, 16'h0000);
    wr(1, st);
    wr(7, c0); wr(8, c1); wr(9, c2);
    wr(10, {2'b0, m0}); wr(11, {2'b0, m1}); wr(12, {2'b0, m2});
    wr(13, {10'b0, tgl});
    wr(0, 16'h0001);
    cyc(n);
    wr(0, 16'h0000);
    cyc(2);
    rd(1, f);
    model(st, f, c0, c1, c2, m0, m1, m2, tgl);
    chk("R8 set/reset outputs", {26'b0, sr_out}, {26'b0, e_sr});
    chk("R9 toggle outputs", {30'b0, tg_out}, {30'b0, e_tg});
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    rd(1, d); chk("R1 timer after reset", d, 16'h0);
    rd(2, d); chk("R1 status after reset", d, 16'h0);
    chk("R1 outputs after reset", {24'b0, tg_out, sr_out}, 32'h0);
    cyc(5);
    rd(1, d); chk("R1 timer holds while off", d, 16'h0);

    // R11 load
    wr(1, 16'hABCD);
    rd(1, d); chk("R11 timer load", d, 16'hABCD);

    // R2 prescaler rates
    for (int s = 1; s <= 4; s++) begin
      wr(0, 16'h0); wr(1, 16'h0);
      wr(0, 16'(s));
      cyc(63);
      wr(0, 16'h0);
      cyc(1);
      rd(1, d); chk($sformatf("R2 divide select %0d", s), d, 16'(64 >> (s - 1)));
    end
    cyc(4);
    rd(1, d); chk("R2 off holds", d, 16'd8);

    // R3 event counting
    wr(1, 16'h0); wr(0, 16'h0005);
    for (int p = 0; p < 7; p++) begin
      ext_evt = 1'b1; cyc(3);
      ext_evt = 1'b0; cyc(3);
    end
    cyc(4);
    rd(1, d); chk("R3 event count", d, 16'd7);

    // R4 external clear
    wr(0, 16'h0); wr(1, 16'h4000); wr(0, 16'h0001);
    cyc(5);
    ext_clr = 1'b1;
    cyc(3);
    rd(1, d); chk("R4 cleared on rising edge", d, 16'h0);
    cyc(3);
    rd(1, d); chk("R4 resumes while held high", d, 16'd3);
    ext_clr = 1'b0;
    wr(0, 16'h0);

    // R5 overflow and R7 clear
    wr(1, 16'hFFFD); wr(0, 16'h0001);
    cyc(4);
    wr(0, 16'h0000);
    cyc(1);
    rd(1, d); chk("R5 wrap value", d, 16'h0002);
    rd(2, d); chk("R5 overflow flag", d, 16'h0010);
    wr(2, 16'h0000);
    rd(2, d); chk("R7 write zero keeps flag", d, 16'h0010);
    wr(2, 16'h0010);
    rd(2, d); chk("R7 write one clears flag", d, 16'h0000);

    // R6 captures: ch0 rising, ch1 falling, ch2 both, ch3 disabled
    wr(0, 16'h3900); wr(1, 16'h1234);
    cap_in = 4'hF; cyc(4);
    rd(2, d); chk("R6 flags after rising", d, 16'h0005);
    rd(3, d); chk("R6 cap0 rising", d, 16'h1234);
    rd(4, d); chk("R6 cap1 ignores rising", d, 16'h0);
    rd(5, d); chk("R6 cap2 both on rising", d, 16'h1234);
    rd(6, d); chk("R6 cap3 disabled", d, 16'h0);
    wr(2, 16'h000F);
    rd(2, d); chk("R7 capture flags cleared", d, 16'h0);
    wr(1, 16'h5678);
    cap_in = 4'h0; cyc(4);
    rd(2, d); chk("R6 flags after falling", d, 16'h0006);
    rd(3, d); chk("R6 cap0 ignores falling", d, 16'h1234);
    rd(4, d); chk("R6 cap1 falling", d, 16'h5678);
    rd(5, d); chk("R6 cap2 both on falling", d, 16'h5678);
    rd(6, d); chk("R6 cap3 still disabled", d, 16'h0);
    wr(2, 16'h000F);
    wr(0, 16'h0000);

    // R10 exact timing: match at 0x0203 sets all and toggles both
    wr(1, 16'h0200); wr(7, 16'h0203); wr(10, 16'h003F); wr(13, 16'h0003);
    wr(0, 16'h0001);
    cyc(3);
    rd(1, d); chk("R10 timer at compare", d, 16'h0203);
    chk("R10 outputs not yet changed", {24'b0, tg_out, sr_out}, 32'h0);
    cyc(1);
    chk("R10 all outputs change together", {24'b0, tg_out, sr_out}, 32'h00FF);
    wr(0, 16'h0000);
    cyc(2);
    e_sr = 6'h3F; e_tg = 2'b11;

    // R8/R9 collisions: set beats reset across compares, double toggle inverts once
    trial(16'h0300, 16'h0305, 16'h0305, 16'h0308,
          14'h000F, 14'h3F00, 14'h0100, 6'b00_01_01, 12);
    // R11 load onto compare value gives no match
    trial(16'h0400, 16'h0400, 16'h0500, 16'h0500, 14'h3F00, 14'h0, 14'h0, 6'b00_00_11, 5);

    for (int t = 0; t < 30; t++) begin
      logic [15:0] st;
      st = 16'($urandom_range(0, 16'hFF00));
      trial(st, st + 16'($urandom_range(1, 30)), st + 16'($urandom_range(1, 30)),
            st + 16'($urandom_range(1, 30)),
            14'($urandom) & 14'h3F3F, 14'($urandom) & 14'h3F3F, 14'($urandom) & 14'h3F3F,
            6'($urandom), int'($urandom_range(10, 40)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule